// File: doc/BRIEF.md
# Page-Bounded Scatter-Gather Descriptor Builder

This block turns one linear transfer request, given as a start address and a byte count, into a list of scatter-gather descriptors. No descriptor may span a page boundary. The first descriptor covers the bytes from the start address up to the end of its page. Every later descriptor covers at most one whole page. Descriptors leave the block one per clock on a write port that feeds a small descriptor RAM, starting at slot 0. The final descriptor carries an end-of-table flag.

A request is rejected at once in three cases: the address or the count does not meet the alignment given by the mask input, the count is zero, or the table would fill before all the bytes are covered. Address translation is the identity, so each descriptor base is the running byte address.

The usual alignment mask is 0x1, which gives 2-byte alignment. A 16-byte mode uses 0xF. A control unit pulses `req_valid` while the block is idle. It then collects descriptor writes until it sees `done` or `err`.

Top module: `dsb_top`

## Requirements
- R1: When the request is accepted, if (address AND mask) or (count AND mask) is nonzero, the block writes no descriptor. On the next cycle it pulses `err` for one cycle with `err_code` = 1 (misaligned).
- R2: An aligned request with a count of zero is rejected the same way with `err_code` = 2. A misaligned zero-count request reports code 1.
- R3: The first descriptor's length is the smaller of the count and (PAGE_BYTES minus the start address modulo PAGE_BYTES).
- R4: Each later descriptor starts on a page boundary. Its length is the smaller of the remaining count and PAGE_BYTES.
- R5: `desc_word` carries the segment length in bits 15:0. Bit 31 is the end-of-table flag, set on the final descriptor only. All other bits are zero.
- R6: Descriptors come out one per clock, with a one-cycle `desc_we`, starting on the second cycle after acceptance. `desc_idx` counts up from 0. Each `desc_base` equals the previous base plus the previous length, and the first equals the start address.
- R7: If the descriptor written at index DEPTH-1 still leaves bytes uncovered, it is written without the end-of-table flag. In that same cycle `err` pulses with `err_code` = 3 (overflow), and the block stops.
- R8: `done` pulses for one cycle together with the final descriptor write. `busy` is high from the cycle after acceptance until the final write or the abort, and is low in the cycle where `done` or `err` appears.
- R9: A `req_valid` that arrives while `busy` is high is ignored and does not change the descriptors being produced.
- R10: While reset is held and after it is released, `busy`, `desc_we`, `done` and `err` are low and `err_code` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_addr | input | ADDR_W (32) | Start byte address |
| req_len | input | CNT_W (24) | Byte count |
| align_mask | input | MASK_W (4) | Alignment mask applied to address and count |
| busy | output | 1 | Descriptor generation in progress |
| desc_we | output | 1 | Descriptor write enable |
| desc_idx | output | IDX_W (4) | Descriptor table slot |
| desc_base | output | ADDR_W (32) | Descriptor base address |
| desc_word | output | 32 | Count word: length in bits 15:0, end-of-table in bit 31 |
| done | output | 1 | Table complete pulse |
| err | output | 1 | Request rejected or aborted pulse |
| err_code | output | 2 | 1 misaligned, 2 zero length, 3 overflow, 0 otherwise |

## Verification
A wrong running address or remaining count shows up on the very next descriptor, as a wrong base or a length that does not end at a page boundary. A wrong slot counter shows as an index step or as overflow being flagged one descriptor early or late. The reference model in the bench predicts every output on every clock, so any such fault is reported in the cycle where it first reaches a port. The checks cover multi-page splits, the exact table fit and one-past overflow, and requests sent while the block is busy.

// File: rtl/dsb_pkg.sv
package dsb_pkg;
   typedef enum logic [1:0] {
      DSB_OK       = 2'd0,
      DSB_MISALIGN = 2'd1,
      DSB_ZERO     = 2'd2,
      DSB_OVERFLOW = 2'd3
   } dsb_err_e;
endpackage

// File: rtl/dsb_req_check.sv
module dsb_req_check
   import dsb_pkg::*;
#(
   parameter int MASK_W = 4,
   parameter int CNT_W  = 24
) (
   input  logic [MASK_W-1:0] addr_lo,
   input  logic [MASK_W-1:0] len_lo,
   input  logic [CNT_W-1:0]  len,
   input  logic [MASK_W-1:0] mask,
   output dsb_err_e          code
);
   initial begin
      if (MASK_W < 1 || MASK_W > CNT_W)
         $error("dsb_req_check: MASK_W out of range");
   end

   logic [MASK_W-1:0] bad_bit;

   // one AND-OR cell per mask bit
   for (genvar b = 0; b < MASK_W; b++) begin : g_bit
      assign bad_bit[b] = mask[b] & (addr_lo[b] | len_lo[b]);
   end

   always_comb begin
      if (|bad_bit)
         code = DSB_MISALIGN;
      else if (len == '0)
         code = DSB_ZERO;
      else
         code = DSB_OK;
   end
endmodule

// File: rtl/dsb_seg_calc.sv
module dsb_seg_calc #(
   parameter int CNT_W      = 24,
   parameter int PAGE_BYTES = 4096,
   localparam int PAGE_W    = $clog2(PAGE_BYTES),
   localparam int SEG_W     = PAGE_W + 1
) (
   input  logic [PAGE_W-1:0] cur_off,
   input  logic [CNT_W-1:0]  rem,
   output logic [SEG_W-1:0]  seg,
   output logic              last
);
   initial begin
      if ((1 << PAGE_W) != PAGE_BYTES)
         $error("dsb_seg_calc: PAGE_BYTES must be a power of two");
      if (CNT_W < SEG_W)
         $error("dsb_seg_calc: CNT_W too small for one page");
   end

   logic [SEG_W-1:0] room;
   logic [CNT_W-1:0] room_w;

   always_comb begin
      room   = SEG_W'(PAGE_BYTES) - {1'b0, cur_off};
      room_w = CNT_W'(room);
      last   = (rem <= room_w);
      seg    = last ? rem[SEG_W-1:0] : room;
   end
endmodule

// File: rtl/dsb_seq.sv
module dsb_seq
   import dsb_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int CNT_W      = 24,
   parameter int PAGE_BYTES = 4096,
   parameter int DEPTH      = 16,
   parameter int LEN_W      = 16,
   parameter int WORD_W     = 32,
   localparam int PAGE_W    = $clog2(PAGE_BYTES),
   localparam int SEG_W     = PAGE_W + 1,
   localparam int IDX_W     = $clog2(DEPTH),
   localparam int PAD_W     = WORD_W - 1 - LEN_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [CNT_W-1:0]  req_len,
   input  dsb_err_e          chk_code,
   input  logic [SEG_W-1:0]  seg,
   input  logic              last,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [CNT_W-1:0]  rem,
   output logic              busy,
   output logic              desc_we,
   output logic [IDX_W-1:0]  desc_idx,
   output logic [ADDR_W-1:0] desc_base,
   output logic [WORD_W-1:0] desc_word,
   output logic              done,
   output logic              err,
   output dsb_err_e          err_code
);
   initial begin
      if (DEPTH < 2) $error("dsb_seq: DEPTH must be at least 2");
      if (PAD_W < 0) $error("dsb_seq: WORD_W too small");
      if (SEG_W > LEN_W) $error("dsb_seq: page does not fit length field");
   end

   logic             running;
   logic [IDX_W-1:0] slot;

   assign busy = running;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running   <= 1'b0;
         cur_addr  <= '0;
         rem       <= '0;
         slot      <= '0;
         desc_we   <= 1'b0;
         desc_idx  <= '0;
         desc_base <= '0;
         desc_word <= '0;
         done      <= 1'b0;
         err       <= 1'b0;
         err_code  <= DSB_OK;
      end else begin
         desc_we  <= 1'b0;
         done     <= 1'b0;
         err      <= 1'b0;
         err_code <= DSB_OK;
         if (!running) begin
            if (req_valid) begin
               if (chk_code != DSB_OK) begin
                  err      <= 1'b1;
                  err_code <= chk_code;
               end else begin
                  running  <= 1'b1;
                  cur_addr <= req_addr;
                  rem      <= req_len;
                  slot     <= '0;
               end
            end
         end else begin
            desc_we   <= 1'b1;
            desc_idx  <= slot;
            desc_base <= cur_addr;
            desc_word <= {last, {PAD_W{1'b0}}, LEN_W'(seg)};
            cur_addr  <= cur_addr + ADDR_W'(seg);
            rem       <= rem - CNT_W'(seg);
            slot      <= slot + 1'b1;
            if (last) begin
               done    <= 1'b1;
               running <= 1'b0;
            end else if (slot == IDX_W'(DEPTH - 1)) begin
               err      <= 1'b1;
               err_code <= DSB_OVERFLOW;
               running  <= 1'b0;
            end
         end
      end
   end

   // R8: completion ends the busy window
   a_r8_done_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && desc_we && $past(busy)));
   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R5: end-of-table flag appears only with completion
   a_r5_eot_last_only: assert property (@(posedge clk) disable iff (!rst_n)
      desc_we |-> (desc_word[WORD_W-1] == done));
   // R6: consecutive slots
   a_r6_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
      (desc_we && desc_idx != '0) |->
         ($past(desc_we) && desc_idx == $past(desc_idx) + 1'b1));
   // R7: overflow only at the final slot
   a_r7_overflow_slot: assert property (@(posedge clk) disable iff (!rst_n)
      (err && err_code == DSB_OVERFLOW) |->
         (desc_we && desc_idx == IDX_W'(DEPTH - 1) && !desc_word[WORD_W-1]));
   // R1: request rejection never writes a descriptor
   a_r1_reject_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (err && err_code != DSB_OVERFLOW) |-> (!desc_we && !$past(busy)));
endmodule

// File: rtl/dsb_top.sv
module dsb_top
   import dsb_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int CNT_W      = 24,
   parameter int MASK_W     = 4,
   parameter int PAGE_BYTES = 4096,
   parameter int DEPTH      = 16,
   parameter int LEN_W      = 16,
   localparam int WORD_W    = 32,
   localparam int PAGE_W    = $clog2(PAGE_BYTES),
   localparam int SEG_W     = PAGE_W + 1,
   localparam int IDX_W     = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [CNT_W-1:0]  req_len,
   input  logic [MASK_W-1:0] align_mask,
   output logic              busy,
   output logic              desc_we,
   output logic [IDX_W-1:0]  desc_idx,
   output logic [ADDR_W-1:0] desc_base,
   output logic [WORD_W-1:0] desc_word,
   output logic              done,
   output logic              err,
   output logic [1:0]        err_code
);
   initial begin
      if (PAGE_W >= ADDR_W) $error("dsb_top: page larger than address space");
      if (MASK_W > ADDR_W)  $error("dsb_top: mask wider than address");
   end

   dsb_err_e          chk_code;
   dsb_err_e          code_q;
   logic [SEG_W-1:0]  seg;
   logic              last;
   logic [ADDR_W-1:0] cur_addr;
   logic [CNT_W-1:0]  rem;

   dsb_req_check #(.MASK_W(MASK_W), .CNT_W(CNT_W)) check_i (
      .addr_lo (req_addr[MASK_W-1:0]),
      .len_lo  (req_len[MASK_W-1:0]),
      .len     (req_len),
      .mask    (align_mask),
      .code    (chk_code)
   );

   dsb_seg_calc #(.CNT_W(CNT_W), .PAGE_BYTES(PAGE_BYTES)) calc_i (
      .cur_off (cur_addr[PAGE_W-1:0]),
      .rem     (rem),
      .seg     (seg),
      .last    (last)
   );

   dsb_seq #(
      .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PAGE_BYTES(PAGE_BYTES),
      .DEPTH(DEPTH), .LEN_W(LEN_W), .WORD_W(WORD_W)
   ) seq_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_addr  (req_addr),
      .req_len   (req_len),
      .chk_code  (chk_code),
      .seg       (seg),
      .last      (last),
      .cur_addr  (cur_addr),
      .rem       (rem),
      .busy      (busy),
      .desc_we   (desc_we),
      .desc_idx  (desc_idx),
      .desc_base (desc_base),
      .desc_word (desc_word),
      .done      (done),
      .err       (err),
      .err_code  (code_q)
   );

   assign err_code = code_q;
endmodule

// File: tb/dsb_top_tb_top.sv
module dsb_top_tb_top;
   localparam int CLK_NS = 10;
   localparam int PAGE   = 4096;
   localparam int DEPTH  = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic [23:0] req_len = '0;
   logic [3:0]  align_mask = 4'h1;
   logic        busy, desc_we, done, err;
   logic [3:0]  desc_idx;
   logic [31:0] desc_base, desc_word;
   logic [1:0]  err_code;

   int checks = 0;
   int errors = 0;

   typedef struct {
      bit          we;
      int          idx;
      logic [31:0] base;
      logic [31:0] word;
      bit          done;
      bit          err;
      int          code;
      bit          busy;
   } exp_t;

   exp_t q[$];

   always #(CLK_NS/2) clk = ~clk;

   dsb_top dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_len(req_len), .align_mask(align_mask), .busy(busy),
      .desc_we(desc_we), .desc_idx(desc_idx), .desc_base(desc_base),
      .desc_word(desc_word), .done(done), .err(err), .err_code(err_code)
   );

   function automatic exp_t idle_e();
      exp_t e;
      e.we = 0; e.idx = 0; e.base = '0; e.word = '0;
      e.done = 0; e.err = 0; e.code = 0; e.busy = 0;
      return e;
   endfunction

   // behavioural reference: whole request expanded to per-cycle outputs
   task automatic build(input logic [31:0] a, input int n, input logic [3:0] m);
      exp_t e;
      q.delete();
      if (((a[3:0] & m) != 0) || ((n & int'(m)) != 0)) begin
         e = idle_e(); e.err = 1; e.code = 1; q.push_back(e);
      end else if (n == 0) begin
         e = idle_e(); e.err = 1; e.code = 2; q.push_back(e);
      end else begin
         longint cur = a;
         int     left = n;
         int     i = 0;
         e = idle_e(); e.busy = 1; q.push_back(e);
         while (1) begin
            int  room = PAGE - int'(cur % PAGE);
            int  len  = (left < room) ? left : room;
            bit  fin, ovf;
            left -= len;
            fin = (left == 0);
            ovf = !fin && (i == DEPTH - 1);
            e = idle_e();
            e.we = 1; e.idx = i; e.base = cur[31:0];
            e.word = (32'(len) & 32'hFFFF) | (fin ? 32'h8000_0000 : 32'h0);
            e.done = fin; e.err = ovf; e.code = ovf ? 3 : 0;
            e.busy = !(fin || ovf);
            q.push_back(e);
            if (fin || ovf) break;
            cur += len;
            i++;
         end
      end
      q.push_back(idle_e());
   endtask

   task automatic compare(input exp_t e, input string tag);
      bit bad;
      checks++;
      bad = (busy !== e.busy) || (desc_we !== e.we) || (done !== e.done) ||
            (err !== e.err) || (int'(err_code) != e.code);
      if (e.we)
         bad = bad || (int'(desc_idx) != e.idx) || (desc_base !== e.base) ||
               (desc_word !== e.word);
      if (bad) begin
         errors++;
         $display("FAIL %s: got busy=%0b we=%0b idx=%0d base=%h word=%h done=%0b err=%0b code=%0d; expected busy=%0b we=%0b idx=%0d base=%h word=%h done=%0b err=%0b code=%0d",
                  tag, busy, desc_we, desc_idx, desc_base, desc_word, done, err, err_code,
                  e.busy, e.we, e.idx, e.base, e.word, e.done, e.err, e.code);
      end
   endtask

   task automatic run(input logic [31:0] a, input int n, input logic [3:0] m,
                      input bit noise, input string tag);
      build(a, n, m);
      @(negedge clk);
      req_valid = 1; req_addr = a; req_len = 24'(n); align_mask = m;
      foreach (q[k]) begin
         @(negedge clk);
         compare(q[k], tag);
         if (noise && q[k].busy) begin
            req_valid = 1; req_addr = 32'h0000_0003; req_len = 24'h0;
         end else begin
            req_valid = 0;
         end
      end
   endtask

   initial begin
      #(CLK_NS * 200000);
      errors++;
      checks++;
      $display("FAIL watchdog: got no finish, expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      // R10: reset state
      repeat (3) @(negedge clk);
      compare(idle_e(), "R10 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      compare(idle_e(), "R10 after reset");

      run(32'h0000_1000, 'h100, 4'h1, 0, "R3 R5 R6 R8 single segment");
      run(32'h0000_0FF0, 'h2020, 4'h1, 0, "R3 R4 R5 R6 page split");
      run(32'h0000_2000, 'h3000, 4'h1, 0, "R4 R6 exact pages");
      run(32'h0001_0FFE, 'h4, 4'h1, 0, "R3 R4 straddle two bytes");
      run(32'h0000_1001, 'h100, 4'h1, 0, "R1 odd address");
      run(32'h0000_1000, 'h101, 4'h1, 0, "R1 odd count");
      run(32'h0000_1008, 'h20, 4'hF, 0, "R1 16-byte mode address");
      run(32'h0000_1008, 'h20, 4'h1, 0, "R1 2-byte mode accepts");
      run(32'h0000_1000, 0, 4'h1, 0, "R2 zero count");
      run(32'h0000_1001, 0, 4'h1, 0, "R2 misaligned zero count gives R1 code");
      run(32'h0000_0010, 16 * PAGE, 4'h1, 0, "R7 overflow");
      run(32'h0000_0000, 16 * PAGE, 4'h1, 0, "R7 exact table fit");
      run(32'h0000_3F00, 'h1300, 4'h1, 1, "R9 request while busy");
      run(32'h0000_5000, 'h40, 4'hF, 0, "R8 after ignored request");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule